// File: doc/BRIEF.md
# Four-Direction Semi-Global Path Cost Aggregator

This block performs the cost aggregation step of semi-global stereo matching. It takes one pixel at a time in raster order. Each pixel arrives as a vector of raw matching costs, one per evaluated disparity candidate. Candidates are listed in order of increasing disparity. A candidate's neighbours are the candidates whose indices differ from it by one. This holds even where the candidate set skips disparities at the far end of the search range.

Four path directions are used: from the left, from above, from the upper-left and from the upper-right. Two path-cost units handle them. Each unit serves two directions in turn, one direction in each of two core cycles per pixel.

- The first unit computes the left path in the first cycle and the upper path in the second.
- The second unit computes the upper-left path in the first cycle and the upper-right path in the second.

The last path vector of the previous pixel is held in registers. The path vectors of the previous image row are kept in per-column storage.

For each candidate, the block returns the saturated sum of the four path costs on a valid/ready output. The penalty for a change of one candidate and the penalty for larger jumps are inputs. Both must be held steady during a frame.

Top module: `sgm_path_agg`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0.
- R2: A beat is accepted on a rising edge where inValid and inReady are both 1. inReady then stays 0, and outValid rises exactly three rising edges after the accepting edge. outValid and outSum hold steady while outReady is 0. inReady returns to 1 on the edge after the one where outValid and outReady are both 1.
- R3: Each direction's cost for candidate d is raw(d) + min(prev(d), prev(d-1)+penaltyNear, prev(d+1)+penaltyNear, minPrev+penaltyFar) − minPrev. Here prev is that direction's vector at the preceding pixel along the path, and minPrev is its smallest entry.
- R4: At column 0, the previous vectors of the left and upper-left directions are all zero.
- R5: On the first row of a frame, the previous vectors of the upper, upper-left and upper-right directions are all zero.
- R6: At the last column (IMG_W−1), the previous vector of the upper-right direction is all zero.
- R7: A beat with inFrameStart=1 is taken as column 0 of the first row. The column advances by one per accepted beat. After column IMG_W−1 it wraps to column 0 of the next row.
- R8: outSum lane d (bits d*SW to d*SW+SW−1) is the sum of the four direction costs for candidate d. The sum is clipped to 2^SW−1 and never wraps.
- R9: Candidate 0 and candidate NUM_D−1 use only their single neighbour in the penalty term. Raw cost lane d occupies bits d*CW to d*CW+CW−1 of inCost.
- R10: The penalties in effect are the current values of penaltyNear and penaltyFar. Changing them between frames changes the results accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat offered |
| inReady | output | 1 | Block can take a beat |
| inFrameStart | input | 1 | Beat is the first pixel of a frame |
| inCost | input | NUM_D*CW | Raw cost per candidate |
| penaltyNear | input | PW | Penalty for a one-candidate change |
| penaltyFar | input | PW | Penalty for a larger jump |
| outValid | output | 1 | Aggregated vector available |
| outReady | input | 1 | Consumer takes the vector |
| outSum | output | NUM_D*SW | Saturated four-direction sum per candidate |

## Verification
Every vector the block stores is fed back into the next pixel or the next row. A wrong register therefore shows at the ports quickly.

- A bad left-path register corrupts outSum on the very next pixel.
- A bad row-storage entry, or a bad column count, first shows one row later, at the same or a neighbouring column.
- An upper-left held value that is captured too late shows one column to the right.
- Border mistakes show only at column 0, at the last column or on the first row.

For these reasons the checks compare every lane of every output against an independent row-by-row model. They run over multi-row frames with random costs, restarted frames and changed penalties.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PH0, ST_PH1, ST_OUT} aggState_t;

  // strobes and position flags from control to datapath
  typedef struct packed {
    logic loadIn;
    logic stepA;
    logic stepB;
    logic firstRow;
    logic firstCol;
    logic lastCol;
  } aggCtrl_t;
endpackage

// File: rtl/sgm_path_unit.sv
module sgm_path_unit #(
  parameter int NUM_D = 50,
  parameter int CW    = 6,
  parameter int LW    = 10,
  parameter int PW    = 8
) (
  input  logic [NUM_D*CW-1:0] costVec,
  input  logic [NUM_D*LW-1:0] prevVec,
  input  logic [PW-1:0]       penNear,
  input  logic [PW-1:0]       penFar,
  output logic [NUM_D*LW-1:0] newVec
);
  localparam int XW = LW + 1;

  logic [LW-1:0] minPrev;

  always_comb begin
    minPrev = prevVec[LW-1:0];
    for (int k = 1; k < NUM_D; k++)
      if (prevVec[k*LW +: LW] < minPrev) minPrev = prevVec[k*LW +: LW];
  end

  for (genvar d = 0; d < NUM_D; d++) begin : g_lane
    logic [XW-1:0] best;
    logic [XW-1:0] lane;
    always_comb begin
      best = XW'(prevVec[d*LW +: LW]);
      if (d > 0)
        if (XW'(prevVec[(d-1)*LW +: LW]) + XW'(penNear) < best)
          best = XW'(prevVec[(d-1)*LW +: LW]) + XW'(penNear);
      if (d < NUM_D-1)
        if (XW'(prevVec[(d+1)*LW +: LW]) + XW'(penNear) < best)
          best = XW'(prevVec[(d+1)*LW +: LW]) + XW'(penNear);
      if (XW'(minPrev) + XW'(penFar) < best)
        best = XW'(minPrev) + XW'(penFar);
      lane = best - XW'(minPrev) + XW'(costVec[d*CW +: CW]);
    end
    assign newVec[d*LW +: LW] = lane[LW-1:0];

    // R3: a path cost never exceeds raw cost plus the far penalty
    always_comb
      assert_path_bound_R3: assert (lane <= XW'(costVec[d*CW +: CW]) + XW'(penFar));
  end
endmodule

// File: rtl/sgm_agg_ctrl.sv
module sgm_agg_ctrl
  import sgm_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int CLW   = $clog2(IMG_W)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           inFrameStart,
  input  logic           outReady,
  output logic           inReady,
  output logic           outValid,
  output aggCtrl_t       ctl,
  output logic [CLW-1:0] col
);
  localparam logic [CLW-1:0] LASTCOL = CLW'(IMG_W - 1);

  aggState_t      state;
  logic [CLW-1:0] posCol, startCol;
  logic           posFirstRow, startFirst, curFirstRow, accept;

  assign accept     = (state == ST_IDLE) && inValid;
  assign startCol   = inFrameStart ? '0 : posCol;
  assign startFirst = inFrameStart | posFirstRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      posCol      <= '0;
      posFirstRow <= 1'b1;
      curFirstRow <= 1'b1;
      col         <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= ST_PH0;
        ST_PH0:  state <= ST_PH1;
        ST_PH1:  state <= ST_OUT;
        default: if (outReady) state <= ST_IDLE;
      endcase
      if (accept) begin
        col         <= startCol;
        curFirstRow <= startFirst;
        if (startCol == LASTCOL) begin
          posCol      <= '0;
          posFirstRow <= 1'b0;
        end else begin
          posCol      <= startCol + 1'b1;
          posFirstRow <= startFirst;
        end
      end
    end
  end

  assign inReady      = (state == ST_IDLE);
  assign outValid     = (state == ST_OUT);
  assign ctl.loadIn   = accept;
  assign ctl.stepA    = (state == ST_PH0);
  assign ctl.stepB    = (state == ST_PH1);
  assign ctl.firstRow = curFirstRow;
  assign ctl.firstCol = (col == '0);
  assign ctl.lastCol  = (col == LASTCOL);

  assert_seq_a_R2: assert property (@(posedge clk) disable iff (!rstN) ctl.loadIn |=> ctl.stepA);
  assert_seq_b_R2: assert property (@(posedge clk) disable iff (!rstN) ctl.stepA |=> ctl.stepB);
  assert_seq_out_R2: assert property (@(posedge clk) disable iff (!rstN) ctl.stepB |=> outValid);
  assert_excl_R2: assert property (@(posedge clk) disable iff (!rstN) !(inReady && outValid));
  assert_frame_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inFrameStart) |=> (col == '0) && curFirstRow);
endmodule

// File: rtl/sgm_agg_datapath.sv
module sgm_agg_datapath
  import sgm_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int NUM_D = 50,
  parameter int CW    = 6,
  parameter int LW    = 10,
  parameter int PW    = 8,
  parameter int SW    = 8,
  parameter int CLW   = $clog2(IMG_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  aggCtrl_t            ctl,
  input  logic [CLW-1:0]      col,
  input  logic [NUM_D*CW-1:0] inCost,
  input  logic [PW-1:0]       penNear,
  input  logic [PW-1:0]       penFar,
  output logic [NUM_D*SW-1:0] outSum
);
  localparam int VW = NUM_D * LW;
  localparam int QW = LW + 2;
  localparam logic [SW-1:0] SATMAX = '1;

  logic [NUM_D*CW-1:0] costReg;
  logic [VW-1:0] hLast, dlHold, hRes, dlRes;
  logic [VW-1:0] lineV [IMG_W];
  logic [VW-1:0] lineDL[IMG_W];
  logic [VW-1:0] lineDR[IMG_W];
  logic [VW-1:0] prevA, prevB, newA, newB;
  logic [CLW-1:0] drIdx;
  logic [NUM_D*SW-1:0] sumNext;

  assign drIdx = ctl.lastCol ? col : col + 1'b1;

  // unit A: left (step A) / up (step B); unit B: up-left / up-right
  always_comb begin
    if (ctl.stepB) begin
      prevA = ctl.firstRow ? '0 : lineV[col];
      prevB = (ctl.firstRow || ctl.lastCol) ? '0 : lineDR[drIdx];
    end else begin
      prevA = ctl.firstCol ? '0 : hLast;
      prevB = (ctl.firstRow || ctl.firstCol) ? '0 : dlHold;
    end
  end

  sgm_path_unit #(.NUM_D(NUM_D), .CW(CW), .LW(LW), .PW(PW)) u_unitA (
    .costVec(costReg), .prevVec(prevA), .penNear(penNear), .penFar(penFar), .newVec(newA));
  sgm_path_unit #(.NUM_D(NUM_D), .CW(CW), .LW(LW), .PW(PW)) u_unitB (
    .costVec(costReg), .prevVec(prevB), .penNear(penNear), .penFar(penFar), .newVec(newB));

  for (genvar d = 0; d < NUM_D; d++) begin : g_sum
    logic [QW-1:0] total;
    assign total = QW'(hRes[d*LW +: LW]) + QW'(dlRes[d*LW +: LW])
                 + QW'(newA[d*LW +: LW]) + QW'(newB[d*LW +: LW]);
    assign sumNext[d*SW +: SW] = (total > QW'(SATMAX)) ? SATMAX : total[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      costReg <= '0;
      hLast   <= '0;
      dlHold  <= '0;
      hRes    <= '0;
      dlRes   <= '0;
      outSum  <= '0;
      for (int i = 0; i < IMG_W; i++) begin
        lineV[i]  <= '0;
        lineDL[i] <= '0;
        lineDR[i] <= '0;
      end
    end else begin
      if (ctl.loadIn) costReg <= inCost;
      if (ctl.stepA) begin
        hRes  <= newA;
        hLast <= newA;
        dlRes <= newB;
      end
      if (ctl.stepB) begin
        lineV[col]  <= newA;
        lineDR[col] <= newB;
        lineDL[col] <= dlRes;
        dlHold      <= lineDL[col];
        outSum      <= sumNext;
      end
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepB && (hRes[LW-1:0] >= LW'(SATMAX))) |=> (outSum[SW-1:0] == SATMAX));
endmodule

// File: rtl/sgm_path_agg.sv
module sgm_path_agg
  import sgm_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int NUM_D = 50,
  parameter int CW    = 6,
  parameter int LW    = 10,
  parameter int PW    = 8,
  parameter int SW    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic                inFrameStart,
  input  logic [NUM_D*CW-1:0] inCost,
  input  logic [PW-1:0]       penaltyNear,
  input  logic [PW-1:0]       penaltyFar,
  output logic                outValid,
  input  logic                outReady,
  output logic [NUM_D*SW-1:0] outSum
);
  localparam int CLW = $clog2(IMG_W);

  aggCtrl_t       ctl;
  logic [CLW-1:0] col;

  sgm_agg_ctrl #(.IMG_W(IMG_W), .CLW(CLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFrameStart(inFrameStart),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .ctl(ctl), .col(col));

  sgm_agg_datapath #(.IMG_W(IMG_W), .NUM_D(NUM_D), .CW(CW), .LW(LW), .PW(PW), .SW(SW),
                     .CLW(CLW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .col(col), .inCost(inCost),
    .penNear(penaltyNear), .penFar(penaltyFar), .outSum(outSum));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSum)));
endmodule

// File: tb/sgm_path_agg_tb.sv
module sgm_path_agg_tb;
  localparam int IMG_W = 8;
  localparam int NUM_D = 50;
  localparam int CW = 6;
  localparam int LW = 10;
  localparam int PW = 8;
  localparam int SW = 8;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inFrameStart = 0, outReady = 0;
  logic inReady, outValid;
  logic [NUM_D*CW-1:0] inCost = '0;
  logic [PW-1:0] penaltyNear = 8'd10, penaltyFar = 8'd40;
  logic [NUM_D*SW-1:0] outSum;

  int total = 0, bad = 0, wdog = 0, satSeen = 0;

  always #10 clk = ~clk;

  sgm_path_agg #(.IMG_W(IMG_W), .NUM_D(NUM_D), .CW(CW), .LW(LW), .PW(PW), .SW(SW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inFrameStart(inFrameStart),
    .inCost(inCost), .penaltyNear(penaltyNear), .penaltyFar(penaltyFar),
    .outValid(outValid), .outReady(outReady), .outSum(outSum));

  // row-by-row reference
  int mPrevV[IMG_W][NUM_D], mPrevDL[IMG_W][NUM_D], mPrevDR[IMG_W][NUM_D];
  int mCurV[IMG_W][NUM_D], mCurDL[IMG_W][NUM_D], mCurDR[IMG_W][NUM_D];
  int mH[NUM_D];
  int mx = 0;
  bit mFirstRow = 1;

  function automatic void pathStep(input int c[NUM_D], input int p[NUM_D], output int r[NUM_D]);
    int mn = p[0];
    for (int k = 1; k < NUM_D; k++) if (p[k] < mn) mn = p[k];
    for (int d = 0; d < NUM_D; d++) begin
      int b = p[d];
      if (d > 0 && p[d-1] + penaltyNear < b) b = p[d-1] + penaltyNear;   // R9 low end
      if (d < NUM_D-1 && p[d+1] + penaltyNear < b) b = p[d+1] + penaltyNear;
      if (mn + penaltyFar < b) b = mn + penaltyFar;
      r[d] = c[d] + b - mn;
    end
  endfunction

  task automatic modelPixel(input int c[NUM_D], input bit sof, output int e[NUM_D]);
    int z[NUM_D], pH[NUM_D], pV[NUM_D], pDL[NUM_D], pDR[NUM_D];
    int rH[NUM_D], rV[NUM_D], rDL[NUM_D], rDR[NUM_D];
    int x;
    if (sof) begin mx = 0; mFirstRow = 1; end
    x = mx;
    for (int d = 0; d < NUM_D; d++) begin
      z[d] = 0;
      pH[d]  = (x == 0) ? 0 : mH[d];                                  // R4
      pV[d]  = mFirstRow ? 0 : mPrevV[x][d];                          // R5
      pDL[d] = (mFirstRow || x == 0) ? 0 : mPrevDL[x-1][d];
      pDR[d] = (mFirstRow || x == IMG_W-1) ? 0 : mPrevDR[(x == IMG_W-1) ? x : x+1][d]; // R6
    end
    pathStep(c, pH, rH); pathStep(c, pV, rV); pathStep(c, pDL, rDL); pathStep(c, pDR, rDR);
    for (int d = 0; d < NUM_D; d++) begin
      int s = rH[d] + rV[d] + rDL[d] + rDR[d];
      e[d] = (s > SMAX) ? SMAX : s;                                   // R8
      mH[d] = rH[d]; mCurV[x][d] = rV[d]; mCurDL[x][d] = rDL[d]; mCurDR[x][d] = rDR[d];
    end
    if (x == IMG_W-1) begin                                           // R7
      mPrevV = mCurV; mPrevDL = mCurDL; mPrevDR = mCurDR;
      mx = 0; mFirstRow = 0;
    end else mx = x + 1;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one pixel, check cadence and every lane
  task automatic sendPixel(input int c[NUM_D], input bit sof, input string req, input int stall);
    int e[NUM_D];
    int lat = 0, mism = 0, firstBad = -1;
    bit busyOk = 1;
    logic [NUM_D*SW-1:0] held;
    modelPixel(c, sof, e);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1; inFrameStart = sof;
    for (int d = 0; d < NUM_D; d++) inCost[d*CW +: CW] = CW'(c[d]);
    @(negedge clk);
    inValid = 0; inFrameStart = 0;
    lat = 1;
    while (!outValid && lat < 10) begin
      if (inReady) busyOk = 0;
      @(negedge clk); lat++;
    end
    check(lat == 3 && busyOk, "R2", "output cadence (negedges to outValid)", lat, 3);
    held = outSum;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(outValid && outSum == held, "R2", "hold under back-pressure", int'(outValid), 1);
    end
    for (int d = 0; d < NUM_D; d++) begin
      if (int'(outSum[d*SW +: SW]) != e[d]) begin
        mism++; if (firstBad < 0) firstBad = d;
      end
      if (e[d] == SMAX) satSeen++;
    end
    if (mism != 0)
      check(0, req, $sformatf("lane %0d sum", firstBad),
            int'(outSum[firstBad*SW +: SW]), e[firstBad]);
    else check(1, req, "", 0, 0);
    outReady = 1;
    @(negedge clk);
    outReady = 0;
    check(inReady == 1, "R2", "ready after output taken", int'(inReady), 1);
  endtask

  task automatic testReset();
    check(inReady == 1, "R1", "inReady after reset", int'(inReady), 1);
    check(outValid == 0, "R1", "outValid after reset", int'(outValid), 0);
  endtask

  task automatic testUniform();
    int c[NUM_D];
    for (int d = 0; d < NUM_D; d++) c[d] = 20;
    for (int p = 0; p < 2*IMG_W; p++) begin
      sendPixel(c, p == 0, "R3", 0);
      check(int'(outSum[0 +: SW]) == 80 && int'(outSum[(NUM_D-1)*SW +: SW]) == 80,
            "R3", "uniform cost sum", int'(outSum[0 +: SW]), 80);
    end
  endtask

  task automatic testRandomFrame(input string req, input int rows);
    int c[NUM_D];
    for (int p = 0; p < rows*IMG_W; p++) begin
      for (int d = 0; d < NUM_D; d++) c[d] = $urandom_range(0, 63);
      sendPixel(c, p == 0, req, 0);
    end
  endtask

  task automatic testSaturation();
    int c[NUM_D];
    penaltyNear = 8'd20; penaltyFar = 8'd200;
    satSeen = 0;
    for (int p = 0; p < 3*IMG_W; p++) begin
      for (int d = 0; d < NUM_D; d++) c[d] = (d == (p*7) % NUM_D) ? 0 : 63;
      sendPixel(c, p == 0, "R8", 0);
    end
    check(satSeen > 0, "R8", "saturated lanes observed", satSeen, 1);
  endtask

  task automatic testBackpressure();
    int c[NUM_D];
    for (int p = 0; p < IMG_W + 2; p++) begin
      for (int d = 0; d < NUM_D; d++) c[d] = $urandom_range(0, 63);
      sendPixel(c, p == 0, "R2", 3);
    end
  endtask

  task automatic testRestart();
    int c[NUM_D];
    for (int p = 0; p < IMG_W + 3; p++) begin          // part of a second row
      for (int d = 0; d < NUM_D; d++) c[d] = $urandom_range(0, 63);
      sendPixel(c, p == 0, "R7", 0);
    end
    for (int p = 0; p < 2*IMG_W; p++) begin            // restart mid-row
      for (int d = 0; d < NUM_D; d++) c[d] = $urandom_range(0, 63);
      sendPixel(c, p == 0, "R7", 0);
    end
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<150000", wdog);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testUniform();
    testRandomFrame("R4 R5 R6 R9", 4);
    penaltyNear = 8'd3; penaltyFar = 8'd90;
    testRandomFrame("R10", 3);
    testSaturation();
    penaltyNear = 8'd10; penaltyFar = 8'd40;
    testBackpressure();
    testRestart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule